// File: doc/BRIEF.md
# Reset-Latched Address Region Decoder

This block turns a 16-bit processor address into chip-select strobes for five destinations: on-chip RAM, the on-chip control register block, EEPROM, ROM and an external expansion bus. Each cycle's address is decoded against fixed windows. The result appears on registered outputs one clock later. The map has holes between the windows, and the operating mode decides what happens to an address that falls into one.

The operating mode comes from two mode pins. These pins are captured on every clock while reset is held low. Once reset is released, the captured code is frozen. In expanded mode, an address that hits no on-chip window goes to the external bus, and the bus read/write strobe follows the processor. In every other mode, such an address selects nothing and raises a one-cycle unmapped-access flag.

Top module: `mmap_decoder`

## Requirements
- R1: An address from 0x0000 to 0x01FF drives `regionSel[0]` (RAM) high in the following cycle.
- R2: An address from 0x1000 to 0x103F drives `regionSel[1]` (register block) high in the following cycle.
- R3: An address from 0xB600 to 0xB7FF drives `regionSel[2]` (EEPROM) high in the following cycle.
- R4: An address from 0xD000 to 0xFFFF drives `regionSel[3]` (ROM) high in the following cycle.
- R5: While `rstN` is low, each clock loads `modeCode` with {`modeB`,`modeA`}. The codes are 2'b10 single chip, 2'b11 expanded, 2'b00 bootstrap and 2'b01 test.
- R6: After `rstN` goes high, `modeCode` keeps its value whatever the mode pins do.
- R7: In expanded mode (2'b11), an address outside all four windows drives `regionSel[4]` and `extEnable` high in the following cycle, with `extRdWr` equal to the `rdWr` of that access. Whenever `extEnable` is low, `extRdWr` rests at 1 (read).
- R8: In any mode other than expanded, an address outside all four windows leaves `regionSel` at zero and `extEnable` low. For that access, `unmappedHit` is high for exactly the following cycle.
- R9: At most one bit of `regionSel` is high in any cycle. During reset, `regionSel`, `extEnable` and `unmappedHit` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; mode pins are sampled while low |
| addr | input | 16 | Processor address |
| rdWr | input | 1 | 1 = read, 0 = write |
| modeA | input | 1 | Mode pin, low bit of the mode code |
| modeB | input | 1 | Mode pin, high bit of the mode code |
| regionSel | output | 5 | One-hot select: 0 RAM, 1 registers, 2 EEPROM, 3 ROM, 4 external |
| extEnable | output | 1 | External bus access in progress |
| extRdWr | output | 1 | External bus read/write strobe |
| modeCode | output | 2 | Latched mode code |
| unmappedHit | output | 1 | Access to an unmapped address in a non-expanded mode |

## Verification
A bad latched mode shows on `modeCode` at the first clock after reset. It also shows on the first gap access, because that access would raise the wrong one of `extEnable` and `unmappedHit`. An off-by-one window edge shows one cycle after an address at that edge. For this reason, both sides of every window boundary are driven in all four modes. The mode pins are also flipped after release, so a missing freeze becomes visible on `modeCode` within a cycle.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int ADDR_W     = 16;
  localparam int NUM_ONCHIP = 4;

  typedef logic [1:0] mode_t;
  localparam mode_t MODE_SINGLE   = 2'b10;
  localparam mode_t MODE_EXPANDED = 2'b11;
  localparam mode_t MODE_BOOT     = 2'b00;
  localparam mode_t MODE_TEST     = 2'b01;

  // Window base and size-minus-one; index is the select bit position.
  localparam logic [NUM_ONCHIP-1:0][ADDR_W-1:0] WIN_BASE =
    {16'hD000, 16'hB600, 16'h1000, 16'h0000};
  localparam logic [NUM_ONCHIP-1:0][ADDR_W-1:0] WIN_SPAN =
    {16'h2FFF, 16'h01FF, 16'h003F, 16'h01FF};

  typedef struct packed {
    logic capture;   // reset held: clear outputs, sample pins
    logic routeExt;  // gaps go to the external bus
    logic flagGaps;  // gaps raise the unmapped flag
  } ctrl_t;
endpackage

// File: rtl/mmap_mode_ctrl.sv
module mmap_mode_ctrl
  import mmap_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  modeA,
  input  logic  modeB,
  output mode_t modeCode,
  output ctrl_t ctrl
);
  mode_t modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= {modeB, modeA};
  end

  always_comb begin
    ctrl.capture  = !rstN;
    ctrl.routeExt = (modeQ == MODE_EXPANDED);
    ctrl.flagGaps = (modeQ != MODE_EXPANDED);
  end

  assign modeCode = modeQ;
endmodule

// File: rtl/mmap_region_path.sv
module mmap_region_path
  import mmap_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int NWIN = NUM_ONCHIP
)(
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          rdWr,
  input  ctrl_t         ctrl,
  output logic [NWIN:0] regionSel,
  output logic          extEnable,
  output logic          extRdWr,
  output logic          unmappedHit
);
  logic [NWIN-1:0] winHit;
  logic            anyHit;
  logic            gapExt;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [AW-1:0] offset;
    assign offset    = addr - WIN_BASE[i];
    assign winHit[i] = (offset <= WIN_SPAN[i]);
  end

  assign anyHit = |winHit;
  assign gapExt = !anyHit && ctrl.routeExt;

  always_ff @(posedge clk) begin
    if (ctrl.capture) begin
      regionSel   <= '0;
      extEnable   <= 1'b0;
      extRdWr     <= 1'b1;
      unmappedHit <= 1'b0;
    end else begin
      regionSel   <= {gapExt, winHit};
      extEnable   <= gapExt;
      extRdWr     <= gapExt ? rdWr : 1'b1;
      unmappedHit <= !anyHit && ctrl.flagGaps;
    end
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdWr,
  input  logic              modeA,
  input  logic              modeB,
  output logic [NUM_ONCHIP:0] regionSel,
  output logic              extEnable,
  output logic              extRdWr,
  output logic [1:0]        modeCode,
  output logic              unmappedHit
);
  ctrl_t ctrl;

  mmap_mode_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeA(modeA), .modeB(modeB),
    .modeCode(modeCode), .ctrl(ctrl)
  );

  mmap_region_path #(.AW(ADDR_W), .NWIN(NUM_ONCHIP)) u_path (
    .clk(clk), .addr(addr), .rdWr(rdWr), .ctrl(ctrl),
    .regionSel(regionSel), .extEnable(extEnable), .extRdWr(extRdWr),
    .unmappedHit(unmappedHit)
  );
endmodule

// File: rtl/mmap_decoder_sva.sv
module mmap_decoder_sva
  import mmap_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdWr,
  input logic              modeA,
  input logic              modeB,
  input logic [NUM_ONCHIP:0] regionSel,
  input logic              extEnable,
  input logic              extRdWr,
  input logic [1:0]        modeCode,
  input logic              unmappedHit
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (regionSel == '0 && !extEnable && !unmappedHit)); // R9
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeCode)); // R6
  AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(addr) <= 16'h01FF) |-> regionSel[0]); // R1
  AST_EXT_MODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    extEnable |-> (modeCode == MODE_EXPANDED && regionSel[NUM_ONCHIP])); // R7
  AST_EXT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && extEnable) |-> (extRdWr == $past(rdWr))); // R7
  AST_GAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    unmappedHit |-> (modeCode != MODE_EXPANDED && regionSel == '0)); // R8
endmodule

bind mmap_decoder mmap_decoder_sva u_sva (.*);

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic        rdWr = 1'b1;
  logic        modeA = 1'b0;
  logic        modeB = 1'b1;
  logic [4:0]  regionSel;
  logic        extEnable, extRdWr, unmappedHit;
  logic [1:0]  modeCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] expMode;

  always #4 clk = ~clk;

  mmap_decoder uut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdWr(rdWr), .modeA(modeA),
    .modeB(modeB), .regionSel(regionSel), .extEnable(extEnable),
    .extRdWr(extRdWr), .modeCode(modeCode), .unmappedHit(unmappedHit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Reference: window index for an address, -1 for a gap
  function automatic int windowOf(input int a);
    if (a <= 32'h01FF) return 0;
    if (a >= 32'h1000 && a <= 32'h103F) return 1;
    if (a >= 32'hB600 && a <= 32'hB7FF) return 2;
    if (a >= 32'hD000) return 3;
    return -1;
  endfunction

  function automatic string tagOf(input int w, input bit expd);
    case (w)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return expd ? "R7" : "R8";
    endcase
  endfunction

  task automatic access(input int a, input bit rw);
    int w;
    bit expd;
    logic [4:0] eSel;
    addr = a[15:0];
    rdWr = rw;
    @(posedge clk);
    @(negedge clk);
    w = windowOf(a);
    expd = (expMode == 2'b11);
    eSel = '0;
    if (w >= 0) eSel[w] = 1'b1;
    else if (expd) eSel[4] = 1'b1;
    chk(regionSel == eSel, tagOf(w, expd), regionSel, eSel);
    chk(extEnable == (w < 0 && expd), "R7", extEnable, (w < 0 && expd));
    chk(extRdWr == ((w < 0 && expd) ? rw : 1'b1), "R7", extRdWr,
        (w < 0 && expd) ? rw : 1);
    chk(unmappedHit == (w < 0 && !expd), "R8", unmappedHit, (w < 0 && !expd));
    chk($countones(regionSel) <= 1, "R9", regionSel, eSel);
    chk(modeCode == expMode, "R6", modeCode, expMode);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int edges[14] = '{32'h0000, 32'h01FF, 32'h0200, 32'h0FFF, 32'h1000,
                      32'h103F, 32'h1040, 32'hB5FF, 32'hB600, 32'hB7FF,
                      32'hB800, 32'hCFFF, 32'hD000, 32'hFFFF};
    logic [1:0] modes[4] = '{2'b10, 2'b11, 2'b00, 2'b01};
    int lfsr = 32'hACE1;
    @(negedge clk);
    foreach (modes[m]) begin
      expMode = modes[m];
      rstN = 1'b0;
      {modeB, modeA} = 2'b00;
      addr = 16'h0000;
      @(posedge clk); @(negedge clk);
      {modeB, modeA} = expMode;
      @(posedge clk); @(negedge clk);
      chk(modeCode == expMode, "R5", modeCode, expMode);
      chk(regionSel == '0 && !extEnable && !unmappedHit, "R9",
          {regionSel, extEnable, unmappedHit}, 0);
      rstN = 1'b1;
      {modeB, modeA} = ~expMode;
      for (int i = 0; i < 14; i++) access(edges[i], i[0]);
      for (int i = 0; i < 40; i++) begin
        lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0)) & 32'hFFFF;
        access(lfsr, lfsr[3]);
      end
      access(32'h4000, 1'b0);
      access(32'h4001, 1'b1);
      access(32'h0100, 1'b0);
      chk(unmappedHit == 1'b0, "R8", unmappedHit, 0);
      {modeB, modeA} = expMode;
      @(posedge clk); @(negedge clk);
      chk(modeCode == expMode, "R6", modeCode, expMode);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule